// File: doc/BRIEF.md
# Serially Configured Clock Fan-out with Per-Output Enables

This block takes one reference clock and fans it out to seven clock outputs. Each output can be switched on or off by a write-only two-wire serial slave that shares the chip with other devices on the same bus. A disabled output sits at logic low. An enabled output copies the reference clock. Enables change only while the reference clock is low, so no output ever shows a shortened high phase.

The slave logic runs on a fast system clock. It oversamples the bus lines after passing them through synchronizer chains. It answers only to the write form of its 7-bit address 1101001, which is the byte 0xD2. After the address it expects two header bytes, whose contents are ignored, and then two control bytes. These are taken strictly in order because no sub-address is decoded. Further bytes are acknowledged and dropped until the next start or stop. Nothing can be read back.

Top module: `sdclk_fanout_ctl`

## Requirements
- R1: Address byte 0xD2 (bits sent MSB first, R/W is the last bit, 0 = write) is acknowledged: the slave pulls SDA low during the ninth SCL high phase, and its drive changes only after an SCL falling edge, a start or a stop.
- R2: An address byte other than 0xD2, including the read form 0xD3, gets no acknowledge, and every byte that follows it is also unacknowledged and ignored until the next start.
- R3: The first two bytes after an acknowledged address are acknowledged, and their values have no effect on any output.
- R4: The third byte after the address controls output 0 with bit 2, output 1 with bit 3 and output 2 with bit 7. A 1 enables the output and a 0 disables it. The other bits are ignored.
- R5: The fourth byte after the address controls output 3 with bit 2, output 4 with bit 3, output 5 with bit 6 and output 6 with bit 7, with the same polarity. The other bits are ignored.
- R6: Bytes after the fourth are acknowledged and change nothing.
- R7: A control byte takes effect only once all eight of its bits have been received. A stop that arrives before a control byte is complete leaves that output group unchanged.
- R8: After reset all seven outputs are enabled and toggling, and the slave leaves SDA released.
- R9: A disabled output stays low for as long as it is disabled.
- R10: An output's enable changes only while the reference clock is low, so every high pulse on an output is a full reference high phase.
- R11: A start seen mid-transfer (repeated start) restarts address decoding, and byte counting begins again from the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial bus clock line as seen at the pin |
| sda_in | input | 1 | Serial bus data line as seen at the pin |
| sda_pull | output | 1 | 1 pulls the open-drain data line low (acknowledge) |
| ref_clk | input | 1 | Reference clock distributed to the outputs |
| clk_out | output | 7 | Gated copies of the reference clock |

## Verification
The main sweep walks all 128 combinations of the seven enable bits. In each pass the ignored control bits are filled with a value that differs from pass to pass, so that a swapped bit position, a wrong polarity or a decoded unused bit is caught. Separate transactions cover each of the following:
- a read address and a foreign address, where nothing may be acknowledged;
- a stop after the first control byte, and a stop in the middle of the second;
- trailing extra bytes;
- a repeated start after two bytes.

Each of these leaves a different output pattern when the byte counting or the abort handling is wrong. A per-output pulse-width monitor catches any high pulse that is shorter than half a reference period.

// File: rtl/sdfo_pkg.sv
package sdfo_pkg;

  localparam int NUM_OUT = 7;

  localparam logic [6:0] SLAVE_ADDR   = 7'h69;
  localparam logic [7:0] WR_ADDR_BYTE = {SLAVE_ADDR, 1'b0};

  // byte index counted from the first byte after the address
  localparam int IDX_W          = 3;
  localparam int CTRL_FIRST_IDX = 2;
  localparam int CTRL_LAST_IDX  = 3;

  // group (0: first control byte, 1: second) and bit position per output
  localparam logic [NUM_OUT-1:0]   OUT_GRP = 7'b1111000;
  localparam logic [3*NUM_OUT-1:0] OUT_BIT = {3'd7, 3'd6, 3'd3, 3'd2, 3'd7, 3'd3, 3'd2};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK,
    ST_SKIP
  } rx_state_e;

endpackage

// File: rtl/sdfo_line_sync.sv
module sdfo_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sdfo_i2c_rx.sv
module sdfo_i2c_rx
  import sdfo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  output logic             sda_pull,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic [IDX_W-1:0] byte_idx
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  rx_state_e        state_q, state_d;
  logic [3:0]       bit_cnt_q, bit_cnt_d;
  logic [7:0]       shreg_q, shreg_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pull_q, pull_d;
  logic             valid_q, valid_d;
  logic             scl_q, sda_q;

  logic scl_rise, scl_fall, start_det, stop_det, bit_full;

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign bit_full  = (bit_cnt_q == 4'd8);

  always_comb begin
    state_d   = state_q;
    bit_cnt_d = bit_cnt_q;
    shreg_d   = shreg_q;
    idx_d     = idx_q;
    pull_d    = pull_q;
    valid_d   = 1'b0;
    if (start_det) begin
      state_d   = ST_ADDR;
      bit_cnt_d = 4'd0;
      pull_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise && !bit_full) begin
            shreg_d   = {shreg_q[6:0], sda_s};
            bit_cnt_d = bit_cnt_q + 4'd1;
          end else if (scl_fall && bit_full) begin
            bit_cnt_d = 4'd0;
            if (state_q == ST_ADDR) begin
              if (shreg_q == WR_ADDR_BYTE) begin
                pull_d  = 1'b1;
                state_d = ST_AACK;
              end else begin
                state_d = ST_SKIP;
              end
            end else begin
              pull_d  = 1'b1;
              valid_d = 1'b1;
              state_d = ST_DACK;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            idx_d   = '0;
            state_d = ST_DATA;
          end
        end
        ST_DACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            state_d = ST_DATA;
            if (idx_q != IDX_MAX) idx_d = idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= 4'd0;
      shreg_q   <= 8'd0;
      idx_q     <= '0;
      pull_q    <= 1'b0;
      valid_q   <= 1'b0;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      state_q   <= state_d;
      bit_cnt_q <= bit_cnt_d;
      shreg_q   <= shreg_d;
      idx_q     <= idx_d;
      pull_q    <= pull_d;
      valid_q   <= valid_d;
      scl_q     <= scl_s;
      sda_q     <= sda_s;
    end
  end

  assign sda_pull   = pull_q;
  assign byte_valid = valid_q;
  assign byte_data  = shreg_q;
  assign byte_idx   = idx_q;

  // R1: data-line drive moves only after an SCL fall, a start or a stop
  p_pull_timing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> $past(scl_fall || start_det || stop_det));

  // R2: once the address is rejected nothing is acknowledged
  p_skip_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !pull_q);

  // R11: no drive while the bus is idle
  p_idle_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !pull_q);
endmodule

// File: rtl/sdfo_enable_regs.sv
module sdfo_enable_regs
  import sdfo_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_valid,
  input  logic [7:0]         byte_data,
  input  logic [IDX_W-1:0]   byte_idx,
  output logic [NUM_OUT-1:0] en
);
  logic [NUM_OUT-1:0] en_q, en_d;
  logic               unused_bits;

  assign unused_bits = ^{byte_data[1:0], byte_data[5:4]};

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_bit
    localparam int          BITPOS = int'(OUT_BIT[3*g +: 3]);
    localparam int          GRP    = OUT_GRP[g] ? 1 : 0;
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(CTRL_FIRST_IDX + GRP);
    logic load;
    assign load = byte_valid && (byte_idx == MY_IDX);
    always_comb begin
      en_d[g] = en_q[g];
      if (load) en_d[g] = byte_data[BITPOS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '1;
    else        en_q <= en_d;
  end

  assign en = en_q;

  // R7: enables move only on a completed byte
  p_full_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> $past(byte_valid));

  // R3: header bytes leave the enables alone
  p_header_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_idx < IDX_W'(CTRL_FIRST_IDX)) |=> $stable(en_q));

  // R6: trailing bytes leave the enables alone
  p_tail_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_idx > IDX_W'(CTRL_LAST_IDX)) |=> $stable(en_q));
endmodule

// File: rtl/sdfo_out_gate.sv
module sdfo_out_gate
  import sdfo_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] en,
  output logic [NUM_OUT-1:0] clk_out
);
  logic [1:0]         rst_ref_q;
  logic               rst_ref_n;
  logic [NUM_OUT-1:0] en_sync;

  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) rst_ref_q <= 2'b00;
    else        rst_ref_q <= {rst_ref_q[0], 1'b1};
  end
  assign rst_ref_n = rst_ref_q[1];

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic [SYNC-1:0] chain_q, chain_d;
    always_comb chain_d = {chain_q[SYNC-2:0], en[g]};
    always_ff @(negedge ref_clk or negedge rst_ref_n) begin
      if (!rst_ref_n) chain_q <= '1;
      else            chain_q <= chain_d;
    end
    assign en_sync[g] = chain_q[SYNC-1];
    assign clk_out[g] = ref_clk & en_sync[g];
  end

  // R10: gate enables switch only in the low phase of the reference clock
  always @(en_sync) begin
    if (rst_ref_n) p_switch_low_r10: assert (!ref_clk);
  end
endmodule

// File: rtl/sdclk_fanout_ctl.sv
module sdclk_fanout_ctl
  import sdfo_pkg::*;
#(
  parameter int LINE_SYNC = 2,
  parameter int GATE_SYNC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull,
  input  logic               ref_clk,
  output logic [NUM_OUT-1:0] clk_out
);
  logic [1:0]         rst_sys_q;
  logic               rst_sys_n;
  logic               scl_s, sda_s;
  logic               byte_valid;
  logic [7:0]         byte_data;
  logic [IDX_W-1:0]   byte_idx;
  logic [NUM_OUT-1:0] en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sys_q <= 2'b00;
    else        rst_sys_q <= {rst_sys_q[0], 1'b1};
  end
  assign rst_sys_n = rst_sys_q[1];

  sdfo_line_sync #(.STAGES(LINE_SYNC)) u_scl_sync (
    .clk(clk), .rst_n(rst_sys_n), .din(scl_in), .dout(scl_s));

  sdfo_line_sync #(.STAGES(LINE_SYNC)) u_sda_sync (
    .clk(clk), .rst_n(rst_sys_n), .din(sda_in), .dout(sda_s));

  sdfo_i2c_rx u_rx (
    .clk(clk), .rst_n(rst_sys_n), .scl_s(scl_s), .sda_s(sda_s),
    .sda_pull(sda_pull), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_idx(byte_idx));

  sdfo_enable_regs u_regs (
    .clk(clk), .rst_n(rst_sys_n), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_idx(byte_idx), .en(en));

  sdfo_out_gate #(.SYNC(GATE_SYNC)) u_gate (
    .ref_clk(ref_clk), .rst_n(rst_n), .en(en), .clk_out(clk_out));
endmodule

// File: tb/tb_sdclk_fanout_ctl.sv
`timescale 1ns/100ps
module tb_sdclk_fanout_ctl;
  localparam int  CLK_PERIOD = 10;
  localparam int  Q          = 4;
  localparam real REF_HALF   = 13.0;
  localparam int  REF_PER    = 26;

  logic       clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_pull;
  logic       sda_bus;
  logic [6:0] clk_out;

  int total = 0;
  int bad   = 0;
  int bad_pulse [7];

  assign sda_bus = sda_m & ~sda_pull;

  sdclk_fanout_ctl dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_pull(sda_pull), .ref_clk(ref_clk), .clk_out(clk_out));

  always #(CLK_PERIOD/2) clk = ~clk;
  initial begin
    #0.5;
    forever #(REF_HALF) ref_clk = ~ref_clk;
  end

  // R10 monitor: every high pulse must last a full reference half period
  for (genvar g = 0; g < 7; g++) begin : g_mon
    real t_rise = -1.0;
    initial bad_pulse[g] = 0;
    always @(posedge clk_out[g]) t_rise = $realtime;
    always @(negedge clk_out[g]) begin
      if (rst_n && t_rise >= 0.0) begin
        if (($realtime - t_rise) < REF_HALF - 0.05 || ($realtime - t_rise) > REF_HALF + 0.05)
          bad_pulse[g]++;
      end
    end
  end

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic qwait();
    #(Q*CLK_PERIOD);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic bus_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
    end
  endtask

  task automatic bus_byte(input logic [7:0] b, output logic ack);
    bus_bits(b, 8);
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    ack = ~sda_bus;
    qwait(); scl_m = 1'b0; qwait();
  endtask

  // address, two header bytes, two control bytes; returns the five acks
  task automatic write_regs(input logic [7:0] c0, input logic [7:0] c1, output logic [4:0] acks);
    logic a;
    bus_start();
    bus_byte(8'hD2, a); acks[4] = a;
    bus_byte(8'hA5, a); acks[3] = a;
    bus_byte(8'h3C, a); acks[2] = a;
    bus_byte(c0, a);    acks[1] = a;
    bus_byte(c1, a);    acks[0] = a;
    bus_stop();
  endtask

  task automatic observe(output logic [6:0] hi, output logic [6:0] rise);
    logic [6:0] prev;
    #(4*REF_PER);
    hi = '0; rise = '0; prev = clk_out;
    for (int n = 0; n < 6*REF_PER; n++) begin
      #1;
      hi   = hi | clk_out;
      rise = rise | (clk_out & ~prev);
      prev = clk_out;
    end
  endtask

  task automatic expect_outs(input string req, input logic [6:0] exp);
    logic [6:0] hi, rise;
    observe(hi, rise);
    chk(req, {18'd0, hi, rise}, {18'd0, exp, exp});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [4:0] acks;
    logic       a;
    logic [7:0] filler, c0, c1;
    logic [6:0] kv;
    int         acc;
    #3;
    #(5*CLK_PERIOD);
    rst_n = 1'b1;
    #(5*CLK_PERIOD);

    // R8: reset state
    chk("R8 sda released", {31'd0, sda_pull}, 32'd0);
    expect_outs("R8 all outputs running", 7'h7F);

    // R2: read form of the address and all following bytes are ignored
    bus_start();
    bus_byte(8'hD3, a); acc = a;
    for (int i = 0; i < 4; i++) begin bus_byte(8'h00, a); acc += a; end
    bus_stop();
    chk("R2 read address not acked", 32'(acc), 32'd0);
    expect_outs("R2 read leaves outputs", 7'h7F);

    // R2: foreign address
    bus_start();
    bus_byte(8'h52, a); acc = a;
    for (int i = 0; i < 4; i++) begin bus_byte(8'h00, a); acc += a; end
    bus_stop();
    chk("R2 foreign address not acked", 32'(acc), 32'd0);
    expect_outs("R2 foreign leaves outputs", 7'h7F);

    // R1 R3 R4: first group off, second on
    write_regs(8'h00, 8'hFF, acks);
    chk("R1 R3 acks", {27'd0, acks}, 32'h1F);
    expect_outs("R4 group0 off", 7'b1111000);

    // R5: second group off
    write_regs(8'hFF, 8'h00, acks);
    expect_outs("R5 group1 off", 7'b0000111);

    // R7: stop after the first control byte keeps the second group
    write_regs(8'h8C, 8'hCC, acks);
    expect_outs("R7 all on again", 7'h7F);
    bus_start();
    bus_byte(8'hD2, a); bus_byte(8'h11, a); bus_byte(8'h22, a); bus_byte(8'h00, a);
    bus_stop();
    expect_outs("R7 stop after ctrl0", 7'b1111000);

    // R7: stop inside the second control byte
    bus_start();
    bus_byte(8'hD2, a); bus_byte(8'h11, a); bus_byte(8'h22, a); bus_byte(8'h8C, a);
    bus_bits(8'h00, 4);
    bus_stop();
    expect_outs("R7 partial ctrl1 ignored", 7'h7F);

    // R6: trailing bytes acked and ignored
    bus_start();
    bus_byte(8'hD2, a); acc = a;
    bus_byte(8'h00, a); acc += a;
    bus_byte(8'h00, a); acc += a;
    bus_byte(8'h8C, a); acc += a;
    bus_byte(8'h00, a); acc += a;
    bus_byte(8'h00, a); acc += a;
    bus_byte(8'h00, a); acc += a;
    bus_byte(8'hFF, a); acc += a;
    bus_stop();
    chk("R6 trailing bytes acked", 32'(acc), 32'd8);
    expect_outs("R6 trailing bytes no effect", 7'b0000111);

    // R11: repeated start restarts decoding
    bus_start();
    bus_byte(8'hD2, a); bus_byte(8'h11, a);
    bus_start();
    bus_byte(8'hD2, a); acc = a;
    bus_byte(8'h33, a); bus_byte(8'h44, a);
    bus_byte(8'h00, a); bus_byte(8'h00, a);
    bus_stop();
    chk("R11 address after repeated start acked", 32'(acc), 32'd1);
    expect_outs("R11 restart byte order", 7'b0000000);

    // R4 R5 R9: sweep of every enable pattern with varying ignored bits
    for (int k = 0; k < 128; k++) begin
      kv     = 7'(k);
      filler = 8'(k*29 + 5);
      c0 = (filler & 8'h73) | {kv[2], 3'b000, kv[1], kv[0], 2'b00};
      c1 = ((filler ^ 8'hA6) & 8'h33) | {kv[6], kv[5], 2'b00, kv[4], kv[3], 2'b00};
      write_regs(c0, c1, acks);
      chk("R1 R3 sweep acks", {27'd0, acks}, 32'h1F);
      expect_outs("R4 R5 R9 sweep pattern", kv);
    end

    // R10: no truncated high pulse seen on any output
    acc = 0;
    for (int g = 0; g < 7; g++) acc += bad_pulse[g];
    chk("R10 short pulses", 32'(acc), 32'd0);

    report();
    $finish;
  end
endmodule